// File: doc/BRIEF.md
# Special-Event Dispatcher with Programmable Interrupt Vectors

This block decides, once per successful interruptible jump, whether the processor carries on to the jump's destination or diverts to a special-event handler, and which handler that is. The jump unit raises `jump_ok` in the cycle its successful interruptible jump reaches the final stage. At that point the block checks three things: whether the status word reports an exception, whether any enabled interrupt source is pending, and whether a source marked non-maskable is pending. It then produces the program counter to load, captures the diverted destination in a saved-PC register, and reports which event was taken.

Reset requests do not wait for a jump. A hard or soft reset request sends execution to the memory base address on the next cycle, whatever the rest of the block is doing. Each interrupt source has its own 32-bit handler address. These addresses are held in a register bank that is read and written over a simple memory-mapped bus. After reset their contents are undefined, so software loads them before it enables any source.

All decisions are registered: outputs change one clock after the qualifying input cycle.

Top module: `sev_dispatch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pc_load`=0, `ev_taken`=0, `ev_code`=0 (none) and `dpc`=0.
- R2: A cycle with `hard_rst_req` or `soft_rst_req` high yields, one cycle later, `pc_load`=1, `next_pc`=RESET_PC, `ev_taken`=1 and `ev_code`=1 (reset). This holds whether or not `jump_ok` is high, and it takes priority over exceptions and interrupts. `dpc` is left unchanged.
- R3: In a cycle without `jump_ok` and without a reset request, no diversion follows. One cycle later `pc_load`=0 and `ev_taken`=0, and `dpc` keeps its value, even if exceptions or interrupts are pending.
- R4: An exception is pending when (`psw[15]`&`psw[31]`) is 1, when (`psw[6:0]`&`psw[22:16]`) is nonzero, or when `trap_en` is 1. On `jump_ok` with an exception pending, the next cycle gives `ev_code`=2, `next_pc`=EXC_VEC, `dpc`=`jump_target`, and `pc_load`=`ev_taken`=1.
- R5: If an exception and an interrupt both qualify, the exception is taken.
- R6: Source n qualifies as an interrupt when `ipend[n]`&`imask[n]` is 1 and either `ien`=1 or `nmi_level[n]`=1. On `jump_ok` with no exception pending and some source qualifying, the result is `ev_code`=3, `ev_src`=n, `next_pc`=the vector of n, and `dpc`=`jump_target`.
- R7: Among qualifying sources, any source with `nmi_level` set beats every source without it. Within each group, the lowest index wins.
- R8: On `jump_ok` when no reset, exception or interrupt qualifies, the block outputs `pc_load`=1, `next_pc`=`jump_target`, `ev_taken`=0 and `ev_code`=0, and `dpc` is unchanged.
- R9: The vector of source n is read and written at byte address VEC_BASE+4·n (default 0x100880). Reads return data one cycle after `mmio_rd`. A read of any other address returns 0.
- R10: `ev_taken` and `pc_load` are single-cycle strobes. They are low in the cycle after a strobe unless a new request arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hard_rst_req | input | 1 | External reset request |
| soft_rst_req | input | 1 | Host processor-only reset request |
| jump_ok | input | 1 | Successful interruptible jump in final stage |
| jump_target | input | 32 | Intended jump destination |
| psw | input | 32 | Processor status word |
| trap_en | input | 1 | Trap flag enable |
| ipend | input | NSRC | Pending interrupt requests |
| imask | input | NSRC | Per-source mask (1 = allowed) |
| nmi_level | input | NSRC | Per-source non-maskable level select |
| ien | input | 1 | Global interrupt enable |
| mmio_addr | input | 32 | Bus byte address |
| mmio_wr | input | 1 | Bus write strobe |
| mmio_rd | input | 1 | Bus read strobe |
| mmio_wdata | input | 32 | Bus write data |
| mmio_rdata | output | 32 | Bus read data, one cycle after read |
| pc_load | output | 1 | Load `next_pc` into the program counter |
| next_pc | output | 32 | Program counter to load |
| dpc | output | 32 | Saved destination PC |
| ev_taken | output | 1 | Event-taken strobe |
| ev_code | output | 2 | 0 none, 1 reset, 2 exception, 3 interrupt |
| ev_src | output | IDX_W | Interrupt source index |

## Verification
The bench first programs every vector with a distinct value, so that a wrong source index shows up as a wrong `next_pc`.

Exceptions are raised through each of the three triggers in turn: the paired bit 15/31, a low-group pair, and the trap bit. A near miss, where the same low bit is paired with a different high bit, must give a plain jump.

Interrupt patterns separate the following cases:
- lowest index winning among several pending sources;
- an NMI-level source at a high index beating a lower maskable one;
- `ien`=0 blocking only the maskable sources;
- `imask` blocking NMI sources too.

Reset requests are tried both with and without a coinciding jump that carries an exception. Idle cycles with pending events are checked to confirm that no diversion occurs and `dpc` is held.

// File: rtl/sev_pkg.sv
// Package: shared event codes for the special-event dispatcher.
// Assumes: the numeric encoding is visible on the ev_code port and fixed.
package sev_pkg;
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_RESET = 2'd1,
        EV_EXC   = 2'd2,
        EV_INT   = 2'd3
    } ev_code_e;
endpackage

// File: rtl/sev_exc_detect.sv
// Module: sev_exc_detect
// Flags a pending exception from the status word: a bitwise match between
// the low flag group {15,6:0} and the enable group {31,22:16}, or the trap
// enable bit. Assumes the status-word bit positions are fixed at 32 bits.
module sev_exc_detect (
    input  logic [31:0] psw,
    input  logic        trap_en,
    output logic        exc_pend
);
    logic [7:0] flag_grp;
    logic [7:0] enab_grp;

    // Gather both groups in matching order and test their intersection.
    always_comb begin
        flag_grp = {psw[15], psw[6:0]};
        enab_grp = {psw[31], psw[22:16]};
        exc_pend = (|(flag_grp & enab_grp)) | trap_en;
    end
endmodule

// File: rtl/sev_prio_pick.sv
// Module: sev_prio_pick
// Finds the lowest set bit of a request vector. Assumes IW is wide enough
// to index N entries; idx is 0 when no request is set.
module sev_prio_pick #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest index is written last and wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/sev_vector_bank.sv
// Module: sev_vector_bank
// Holds one handler address per interrupt source. These are reachable over a
// simple bus at VEC_BASE + 4*n, with read data registered (one cycle). The
// vectors themselves have no reset. Assumes VEC_BASE is aligned to the
// window size (NSRC*4 rounded up to a power of two).
module sev_vector_bank #(
    parameter int          NSRC     = 32,
    parameter int          IW       = 5,
    parameter int          AW       = 32,
    parameter logic [31:0] VEC_BASE = 32'h0010_0880
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [IW-1:0] sel_idx,
    output logic [31:0]   sel_vec
);
    localparam int LSB_HI = IW + 2;

    logic [31:0]   vec_q [NSRC];
    logic          hit;
    logic [IW-1:0] slot;

    // Decode the bus address into a hit flag and a slot number.
    always_comb begin
        slot = addr[LSB_HI-1:2];
        hit  = (addr[AW-1:LSB_HI] == VEC_BASE[AW-1:LSB_HI])
               && (addr[1:0] == 2'b00)
               && (int'(slot) < NSRC);
    end

    // Per-slot vector storage, written by the bus; no reset by design.
    for (genvar g = 0; g < NSRC; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (wr && hit && (int'(slot) == g)) vec_q[g] <= wdata;
        end
    end

    // Registered bus read; unmapped addresses read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (rd && hit)  rdata <= vec_q[slot];
        else if (rd)         rdata <= '0;
    end

    // Dispatch-side read port for the selected source.
    always_comb sel_vec = vec_q[sel_idx];
endmodule

// File: rtl/sev_dispatch.sv
// Module: sev_dispatch (top)
// Decides the next program counter at each successful interruptible jump,
// diverting to the exception vector or to a per-source interrupt vector.
// A reset request overrides everything at any cycle. All outputs are
// registered one cycle after the deciding input cycle.
// Assumes jump_ok is high for one cycle per final-stage jump and that the
// requesters clear their own pending bits.
module sev_dispatch #(
    parameter int          NSRC     = 32,
    parameter logic [31:0] RESET_PC = 32'h0100_0000,
    parameter logic [31:0] EXC_VEC  = 32'h0100_0020,
    parameter logic [31:0] VEC_BASE = 32'h0010_0880,
    localparam int         IDX_W    = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_rst_req,
    input  logic             soft_rst_req,
    input  logic             jump_ok,
    input  logic [31:0]      jump_target,
    input  logic [31:0]      psw,
    input  logic             trap_en,
    input  logic [NSRC-1:0]  ipend,
    input  logic [NSRC-1:0]  imask,
    input  logic [NSRC-1:0]  nmi_level,
    input  logic             ien,
    input  logic [31:0]      mmio_addr,
    input  logic             mmio_wr,
    input  logic             mmio_rd,
    input  logic [31:0]      mmio_wdata,
    output logic [31:0]      mmio_rdata,
    output logic             pc_load,
    output logic [31:0]      next_pc,
    output logic [31:0]      dpc,
    output logic             ev_taken,
    output logic [1:0]       ev_code,
    output logic [IDX_W-1:0] ev_src
);
    import sev_pkg::*;

    logic             exc_pend;
    logic [NSRC-1:0]  nmi_req;
    logic [NSRC-1:0]  mask_req;
    logic             nmi_any;
    logic             mask_any;
    logic [IDX_W-1:0] nmi_idx;
    logic [IDX_W-1:0] mask_idx;
    logic [IDX_W-1:0] win_idx;
    logic             int_any;
    logic [31:0]      win_vec;

    sev_exc_detect u_exc (
        .psw      (psw),
        .trap_en  (trap_en),
        .exc_pend (exc_pend)
    );

    // Split qualifying sources into the non-maskable and maskable groups.
    always_comb begin
        nmi_req  = ipend & imask & nmi_level;
        mask_req = ipend & imask & ~nmi_level & {NSRC{ien}};
    end

    sev_prio_pick #(.N(NSRC), .IW(IDX_W)) u_pick_nmi (
        .req (nmi_req),
        .any (nmi_any),
        .idx (nmi_idx)
    );

    sev_prio_pick #(.N(NSRC), .IW(IDX_W)) u_pick_mask (
        .req (mask_req),
        .any (mask_any),
        .idx (mask_idx)
    );

    // Non-maskable group wins over the maskable group.
    always_comb begin
        win_idx = nmi_any ? nmi_idx : mask_idx;
        int_any = nmi_any | mask_any;
    end

    sev_vector_bank #(
        .NSRC     (NSRC),
        .IW       (IDX_W),
        .AW       (32),
        .VEC_BASE (VEC_BASE)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (mmio_addr),
        .wr      (mmio_wr),
        .rd      (mmio_rd),
        .wdata   (mmio_wdata),
        .rdata   (mmio_rdata),
        .sel_idx (win_idx),
        .sel_vec (win_vec)
    );

    // Registered dispatch decision: reset, then exception, interrupt, plain jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load  <= 1'b0;
            next_pc  <= RESET_PC;
            dpc      <= '0;
            ev_taken <= 1'b0;
            ev_code  <= EV_NONE;
            ev_src   <= '0;
        end else begin
            pc_load  <= 1'b0;
            ev_taken <= 1'b0;
            ev_code  <= EV_NONE;
            ev_src   <= '0;
            if (hard_rst_req || soft_rst_req) begin
                pc_load  <= 1'b1;
                next_pc  <= RESET_PC;
                ev_taken <= 1'b1;
                ev_code  <= EV_RESET;
            end else if (jump_ok) begin
                pc_load <= 1'b1;
                if (exc_pend) begin
                    next_pc  <= EXC_VEC;
                    dpc      <= jump_target;
                    ev_taken <= 1'b1;
                    ev_code  <= EV_EXC;
                end else if (int_any) begin
                    next_pc  <= win_vec;
                    dpc      <= jump_target;
                    ev_taken <= 1'b1;
                    ev_code  <= EV_INT;
                    ev_src   <= win_idx;
                end else begin
                    next_pc  <= jump_target;
                end
            end
        end
    end
endmodule

// File: rtl/sev_dispatch_chk.sv
// Module: sev_dispatch_chk
// Temporal checks on the dispatcher, bound into every sev_dispatch instance.
// Keeps a one-cycle copy of the qualifying interrupt sets to judge the
// source index it reports.
module sev_dispatch_chk #(
    parameter int          NSRC     = 32,
    parameter logic [31:0] RESET_PC = 32'h0100_0000,
    parameter logic [31:0] EXC_VEC  = 32'h0100_0020,
    localparam int         IDX_W    = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hard_rst_req,
    input logic             soft_rst_req,
    input logic             jump_ok,
    input logic [NSRC-1:0]  ipend,
    input logic [NSRC-1:0]  imask,
    input logic [NSRC-1:0]  nmi_level,
    input logic             ien,
    input logic             pc_load,
    input logic [31:0]      next_pc,
    input logic [31:0]      dpc,
    input logic             ev_taken,
    input logic [1:0]       ev_code,
    input logic [IDX_W-1:0] ev_src
);
    logic [NSRC-1:0] elig_q;
    logic [NSRC-1:0] nmi_elig_q;

    // Remember last cycle's qualifying and non-maskable qualifying sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_q     <= '0;
            nmi_elig_q <= '0;
        end else begin
            elig_q     <= ipend & imask & (nmi_level | {NSRC{ien}});
            nmi_elig_q <= ipend & imask & nmi_level;
        end
    end

    AST_RESET_REQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_rst_req || soft_rst_req) |=> (pc_load && next_pc == RESET_PC && ev_code == 2'd1)); // R2
    AST_IDLE_NO_DIVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_ok && !hard_rst_req && !soft_rst_req) |=> (!pc_load && !ev_taken)); // R3
    AST_DPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_ok || hard_rst_req || soft_rst_req) |=> $stable(dpc)); // R3
    AST_EXC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == 2'd2) |-> (next_pc == EXC_VEC && pc_load)); // R4
    AST_INT_SRC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == 2'd3) |-> elig_q[ev_src]); // R6
    AST_NMI_GROUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == 2'd3 && (|nmi_elig_q)) |-> nmi_elig_q[ev_src]); // R7
    AST_CODE_MATCHES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_taken == (ev_code != 2'd0)); // R8
endmodule

bind sev_dispatch sev_dispatch_chk #(
    .NSRC     (NSRC),
    .RESET_PC (RESET_PC),
    .EXC_VEC  (EXC_VEC)
) u_chk (.*);

// File: tb/sev_dispatch_bench.sv
module sev_dispatch_bench;
    localparam int          NSRC     = 32;
    localparam logic [31:0] RESET_PC = 32'h0100_0000;
    localparam logic [31:0] EXC_VEC  = 32'h0100_0020;
    localparam logic [31:0] VEC_BASE = 32'h0010_0880;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hard_rst_req = 1'b0, soft_rst_req = 1'b0, jump_ok = 1'b0;
    logic [31:0] jump_target = '0, psw = '0;
    logic        trap_en = 1'b0, ien = 1'b0;
    logic [31:0] ipend = '0, imask = '0, nmi_level = '0;
    logic [31:0] mmio_addr = '0, mmio_wdata = '0;
    logic        mmio_wr = 1'b0, mmio_rd = 1'b0;
    logic [31:0] mmio_rdata, next_pc, dpc;
    logic        pc_load, ev_taken;
    logic [1:0]  ev_code;
    logic [4:0]  ev_src;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sev_dispatch #(
        .NSRC(NSRC), .RESET_PC(RESET_PC), .EXC_VEC(EXC_VEC), .VEC_BASE(VEC_BASE)
    ) u_sev_dispatch (
        .clk(clk), .rst_n(rst_n), .hard_rst_req(hard_rst_req), .soft_rst_req(soft_rst_req),
        .jump_ok(jump_ok), .jump_target(jump_target), .psw(psw), .trap_en(trap_en),
        .ipend(ipend), .imask(imask), .nmi_level(nmi_level), .ien(ien),
        .mmio_addr(mmio_addr), .mmio_wr(mmio_wr), .mmio_rd(mmio_rd),
        .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata), .pc_load(pc_load),
        .next_pc(next_pc), .dpc(dpc), .ev_taken(ev_taken), .ev_code(ev_code),
        .ev_src(ev_src)
    );

    function automatic logic [31:0] vec_val(input int n);
        return 32'h0040_0000 + 32'(n) * 32'h0000_0140;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); mmio_addr = a; mmio_wdata = d; mmio_wr = 1'b1;
        @(negedge clk); mmio_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk); mmio_addr = a; mmio_rd = 1'b1;
        @(negedge clk); mmio_rd = 1'b0; d = mmio_rdata;
    endtask

    // One-cycle final-stage jump; outputs sampled at the following negedge.
    task automatic do_jump(input logic [31:0] tgt);
        @(negedge clk); jump_target = tgt; jump_ok = 1'b1;
        @(negedge clk); jump_ok = 1'b0;
    endtask

    task automatic clear_events();
        @(negedge clk);
        psw = '0; trap_en = 1'b0; ipend = '0; imask = '0; nmi_level = '0; ien = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 pc_load", 32'(pc_load), 0);
        chk("R1 ev_taken", 32'(ev_taken), 0);
        chk("R1 ev_code", 32'(ev_code), 0);
        chk("R1 dpc", dpc, 0);
    endtask

    task automatic t_vectors();
        logic [31:0] d;
        for (int i = 0; i < NSRC; i++) bus_write(VEC_BASE + 32'(4 * i), vec_val(i));
        bus_read(VEC_BASE, d);              chk("R9 read vec0", d, vec_val(0));
        bus_read(VEC_BASE + 32'h7C, d);     chk("R9 read vec31", d, vec_val(31));
        bus_read(VEC_BASE + 32'h28, d);     chk("R9 read vec10", d, vec_val(10));
        bus_read(VEC_BASE + 32'h80, d);     chk("R9 unmapped above", d, 0);
        bus_read(VEC_BASE - 32'h4, d);      chk("R9 unmapped below", d, 0);
    endtask

    task automatic t_plain_jump();
        logic [31:0] d0;
        d0 = dpc;
        do_jump(32'h0000_1234);
        chk("R8 pc_load", 32'(pc_load), 1);
        chk("R8 next_pc", next_pc, 32'h0000_1234);
        chk("R8 ev_taken", 32'(ev_taken), 0);
        chk("R8 ev_code", 32'(ev_code), 0);
        chk("R8 dpc held", dpc, d0);
        @(negedge clk);
        chk("R10 pc_load drop", 32'(pc_load), 0);
    endtask

    task automatic t_no_jump();
        logic [31:0] d0;
        d0 = dpc;
        @(negedge clk); trap_en = 1'b1; ipend = 32'hFFFF_FFFF; imask = 32'hFFFF_FFFF; ien = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 no pc_load", 32'(pc_load), 0);
        chk("R3 no ev_taken", 32'(ev_taken), 0);
        chk("R3 dpc held", dpc, d0);
        clear_events();
    endtask

    task automatic t_exceptions();
        @(negedge clk); psw = 32'h0008_0008;  // bit 3 with bit 19
        do_jump(32'h0000_2000);
        chk("R4 low pair code", 32'(ev_code), 2);
        chk("R4 low pair next_pc", next_pc, EXC_VEC);
        chk("R4 low pair dpc", dpc, 32'h0000_2000);
        chk("R4 low pair taken", 32'(ev_taken), 1);
        @(negedge clk);
        chk("R10 ev_taken drop", 32'(ev_taken), 0);
        @(negedge clk); psw = 32'h8000_8000;  // bit 15 with bit 31
        do_jump(32'h0000_2100);
        chk("R4 bit15/31 code", 32'(ev_code), 2);
        chk("R4 bit15/31 dpc", dpc, 32'h0000_2100);
        @(negedge clk); psw = '0; trap_en = 1'b1;
        do_jump(32'h0000_2200);
        chk("R4 trap code", 32'(ev_code), 2);
        @(negedge clk); trap_en = 1'b0; psw = 32'h0010_0008;  // bit 3 with bit 20: no match
        do_jump(32'h0000_2300);
        chk("R4 near miss code", 32'(ev_code), 0);
        chk("R4 near miss next_pc", next_pc, 32'h0000_2300);
        chk("R4 near miss dpc held", dpc, 32'h0000_2200);
        clear_events();
    endtask

    task automatic t_exc_over_int();
        @(negedge clk); psw = 32'h0001_0001; ipend = 32'h1; imask = 32'h1; nmi_level = 32'h1; ien = 1'b1;
        do_jump(32'h0000_3000);
        chk("R5 exception wins", 32'(ev_code), 2);
        chk("R5 next_pc", next_pc, EXC_VEC);
        clear_events();
    endtask

    task automatic t_interrupts();
        @(negedge clk); ipend = 32'h0000_00F0; imask = 32'hFFFF_FFFF; ien = 1'b1;
        do_jump(32'h0000_4000);
        chk("R7 lowest index src", 32'(ev_src), 4);
        chk("R6 int code", 32'(ev_code), 3);
        chk("R6 vector", next_pc, vec_val(4));
        chk("R6 dpc", dpc, 32'h0000_4000);
        @(negedge clk); ipend = 32'h0010_0004; nmi_level = 32'h0010_0000;
        do_jump(32'h0000_4100);
        chk("R7 nmi beats lower", 32'(ev_src), 20);
        chk("R7 nmi vector", next_pc, vec_val(20));
        @(negedge clk); ien = 1'b0;
        do_jump(32'h0000_4200);
        chk("R6 nmi ignores ien", 32'(ev_src), 20);
        chk("R6 nmi code", 32'(ev_code), 3);
        @(negedge clk); ipend = 32'h0000_0004;
        do_jump(32'h0000_4300);
        chk("R6 ien=0 blocks maskable", 32'(ev_code), 0);
        chk("R6 ien=0 next_pc", next_pc, 32'h0000_4300);
        chk("R6 ien=0 dpc held", dpc, 32'h0000_4200);
        @(negedge clk); ipend = 32'h0010_0000; imask = 32'hFFEF_FFFF;
        do_jump(32'h0000_4400);
        chk("R6 mask blocks nmi", 32'(ev_code), 0);
        @(negedge clk); ipend = 32'h8000_0000; imask = 32'hFFFF_FFFF; ien = 1'b1; nmi_level = '0;
        do_jump(32'h0000_4500);
        chk("R6 top source", 32'(ev_src), 31);
        chk("R6 top vector", next_pc, vec_val(31));
        clear_events();
    endtask

    task automatic t_reset_req();
        logic [31:0] d0;
        d0 = dpc;
        @(negedge clk); soft_rst_req = 1'b1; trap_en = 1'b1; jump_target = 32'h0000_5000; jump_ok = 1'b1;
        @(negedge clk); soft_rst_req = 1'b0; jump_ok = 1'b0; trap_en = 1'b0;
        chk("R2 soft code", 32'(ev_code), 1);
        chk("R2 soft next_pc", next_pc, RESET_PC);
        chk("R2 soft dpc held", dpc, d0);
        chk("R2 soft pc_load", 32'(pc_load), 1);
        @(negedge clk); hard_rst_req = 1'b1;
        @(negedge clk); hard_rst_req = 1'b0;
        chk("R2 hard code", 32'(ev_code), 1);
        chk("R2 hard taken", 32'(ev_taken), 1);
        @(negedge clk);
        chk("R10 strobe ends", 32'(ev_taken), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_vectors();
        t_plain_jump();
        t_no_jump();
        t_exceptions();
        t_exc_over_int();
        t_interrupts();
        t_reset_req();
        summary();
    end
endmodule